// File: doc/BRIEF.md
# Vector Floating-Point Class Tester

This block inspects a 128-bit vector operand and decides, for every IEEE-754 element in it, whether the element belongs to one of a set of special classes chosen by the caller. A precision select splits the operand either into four 32-bit single-precision lanes or into two 64-bit double-precision lanes. Lane 0 sits in the least significant bits in both modes.

A 7-bit class mask chooses the classes that count as a hit. NaN has one mask bit. Infinity, zero and denormal each have one bit per sign. The block does not take the mask as a port. It pulls the mask out of a 32-bit instruction word, in which the mask bits are spread across three separate fields.

Each result lane is filled with ones when its element hits and with zeros when it does not. The result is registered on a valid strobe and comes out with its own valid strobe one clock later.

Top module: `fp_class_tester`

## Requirements
- R1: With `dp_sel_i` = 0 the operand is four 32-bit lanes. Lane k occupies bits [32k+31:32k]. Each lane has 1 sign bit (its top bit), an 8-bit exponent and a 23-bit fraction.
- R2: With `dp_sel_i` = 1 the operand is two 64-bit lanes. Lane k occupies bits [64k+63:64k]. Each lane has 1 sign bit (its top bit), an 11-bit exponent and a 52-bit fraction.
- R3: Each result lane is all ones when its element hits a selected class and all zeros otherwise.
- R4: The class mask is built from the instruction word as follows: mask[4:0] = `insn_i`[20:16], mask[5] = `insn_i`[2], mask[6] = `insn_i`[6]. All other instruction bits have no effect.
- R5: An element with an all-ones exponent and a nonzero fraction is a NaN. It hits when mask[6] is set, whatever its sign and whether it is quiet or signaling.
- R6: An element with an all-ones exponent and a zero fraction is an infinity. It hits on mask[5] when positive and on mask[4] when negative.
- R7: An element with a zero exponent and a zero fraction is a zero. It hits on mask[3] when positive and on mask[2] when negative. A zero is never treated as a denormal.
- R8: An element with a zero exponent and a nonzero fraction is a denormal. It hits on mask[1] when positive and on mask[0] when negative.
- R9: A normal finite element never hits, whatever the mask.
- R10: Each lane's result depends only on its own element. Neighbouring lanes have no effect on it.
- R11: The result and `valid_o` appear at the first rising clock edge after the edge that samples `valid_i` high. `valid_o` is high for exactly those cycles.
- R12: Reset clears `result_o` and `valid_o` to zero. While `valid_i` is low, `result_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand and instruction are valid this cycle |
| dp_sel_i | input | 1 | 1: two double lanes, 0: four single lanes |
| insn_i | input | 32 | Instruction word carrying the scattered class mask |
| vec_i | input | 128 | Vector operand |
| valid_o | output | 1 | Result valid strobe |
| result_o | output | 128 | Per-lane all-ones/all-zeros hit result |

## Verification
Every classification result is due one rising edge after the edge that samples `valid_i`. The bench therefore drives each transaction on a falling edge and reads `result_o` and `valid_o` on the next falling edge, halfway between that register edge and the following one. The hold behaviour is checked the same way: `valid_i` is dropped with a different operand applied, and the bench confirms one falling edge later that the result is unchanged and `valid_o` is low. The reset value is read on a falling edge before any strobe has been given.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned MASK_W = 7;

  // instruction field positions of the class mask
  localparam int unsigned INSN_LO_POS  = 16;
  localparam int unsigned INSN_LO_W    = 5;
  localparam int unsigned INSN_B5_POS  = 2;
  localparam int unsigned INSN_B6_POS  = 6;

  // mask bit indices; +/- pairs are adjacent with the positive bit above
  localparam int unsigned MB_DEN_NEG  = 0;
  localparam int unsigned MB_DEN_POS  = 1;
  localparam int unsigned MB_ZERO_NEG = 2;
  localparam int unsigned MB_ZERO_POS = 3;
  localparam int unsigned MB_INF_NEG  = 4;
  localparam int unsigned MB_INF_POS  = 5;
  localparam int unsigned MB_NAN      = 6;

  typedef logic [MASK_W-1:0] class_mask_t;

  typedef enum logic [2:0] {
    CLS_NORMAL = 3'd0,
    CLS_NAN    = 3'd1,
    CLS_INF    = 3'd2,
    CLS_ZERO   = 3'd3,
    CLS_DENORM = 3'd4
  } fp_class_e;
endpackage

// File: rtl/fpc_mask_extract.sv
module fpc_mask_extract
  import fpc_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output class_mask_t       mask_o
);
  always_comb begin
    mask_o = '0;
    mask_o[INSN_LO_W-1:0] = insn_i[INSN_LO_POS +: INSN_LO_W];
    mask_o[MB_INF_POS]    = insn_i[INSN_B5_POS];
    mask_o[MB_NAN]        = insn_i[INSN_B6_POS];
  end
endmodule

// File: rtl/fpc_lane_classify.sv
module fpc_lane_classify
  import fpc_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned ELEM_W = EXP_W + FRAC_W + 1
) (
  input  logic [ELEM_W-1:0] elem_i,
  input  class_mask_t       mask_i,
  output logic              hit_o
);
  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_ones, exp_zero, frac_nz;
  fp_class_e         cls;

  assign sign     = elem_i[ELEM_W-1];
  assign expo     = elem_i[FRAC_W +: EXP_W];
  assign frac     = elem_i[FRAC_W-1:0];
  assign exp_ones = &expo;
  assign exp_zero = ~|expo;
  assign frac_nz  = |frac;

  // priority: NaN, infinity, zero, denormal
  always_comb begin
    if (exp_ones && frac_nz)       cls = CLS_NAN;
    else if (exp_ones)             cls = CLS_INF;
    else if (exp_zero && !frac_nz) cls = CLS_ZERO;
    else if (exp_zero)             cls = CLS_DENORM;
    else                           cls = CLS_NORMAL;
  end

  always_comb begin
    unique case (cls)
      CLS_NAN:    hit_o = mask_i[MB_NAN];
      CLS_INF:    hit_o = sign ? mask_i[MB_INF_NEG]  : mask_i[MB_INF_POS];
      CLS_ZERO:   hit_o = sign ? mask_i[MB_ZERO_NEG] : mask_i[MB_ZERO_POS];
      CLS_DENORM: hit_o = sign ? mask_i[MB_DEN_NEG]  : mask_i[MB_DEN_POS];
      default:    hit_o = 1'b0;
    endcase
  end

  // a finite element with a live exponent never hits
  always_comb begin
    if (!exp_ones && !exp_zero) begin
      p_normal_nohit_r9: assert (!hit_o);
    end
  end
endmodule

// File: rtl/fpc_out_reg.sv
module fpc_out_reg #(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

  p_valid_lat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_no_spurious_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: rtl/fp_class_tester.sv
module fp_class_tester
  import fpc_pkg::*;
#(
  parameter int unsigned VEC_W     = 128,
  parameter int unsigned SP_EXP_W  = 8,
  parameter int unsigned SP_FRAC_W = 23,
  parameter int unsigned DP_EXP_W  = 11,
  parameter int unsigned DP_FRAC_W = 52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              dp_sel_i,
  input  logic [31:0]       insn_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              valid_o,
  output logic [VEC_W-1:0]  result_o
);
  localparam int unsigned SP_W     = SP_EXP_W + SP_FRAC_W + 1;
  localparam int unsigned DP_W     = DP_EXP_W + DP_FRAC_W + 1;
  localparam int unsigned SP_LANES = VEC_W / SP_W;
  localparam int unsigned DP_LANES = VEC_W / DP_W;

  class_mask_t         mask;
  logic [SP_LANES-1:0] sp_hit;
  logic [DP_LANES-1:0] dp_hit;
  logic [VEC_W-1:0]    sp_res, dp_res, res_d;

  fpc_mask_extract u_mask (
    .insn_i (insn_i),
    .mask_o (mask)
  );

  for (genvar i = 0; i < SP_LANES; i++) begin : g_sp
    fpc_lane_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_cls (
      .elem_i (vec_i[i*SP_W +: SP_W]),
      .mask_i (mask),
      .hit_o  (sp_hit[i])
    );
    assign sp_res[i*SP_W +: SP_W] = {SP_W{sp_hit[i]}};
  end

  for (genvar j = 0; j < DP_LANES; j++) begin : g_dp
    fpc_lane_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_cls (
      .elem_i (vec_i[j*DP_W +: DP_W]),
      .mask_i (mask),
      .hit_o  (dp_hit[j])
    );
    assign dp_res[j*DP_W +: DP_W] = {DP_W{dp_hit[j]}};
  end

  assign res_d = dp_sel_i ? dp_res : sp_res;

  fpc_out_reg #(.DATA_W(VEC_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (res_d),
    .valid_o (valid_o),
    .data_o  (result_o)
  );

  // every single-width chunk of the output is uniform
  logic [SP_LANES-1:0] chunk_ok;
  for (genvar k = 0; k < SP_LANES; k++) begin : g_chk
    assign chunk_ok[k] = (&result_o[k*SP_W +: SP_W]) || !(|result_o[k*SP_W +: SP_W]);
  end

  p_lane_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> &chunk_ok);
  p_zero_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[20:16] == '0 && !insn_i[2] && !insn_i[6]) |=> result_o == '0);
  p_dp_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dp_sel_i) |=> (result_o[63:32] == result_o[31:0]) &&
                              (result_o[127:96] == result_o[95:64]));
endmodule

// File: tb/sim_fp_class_tester.sv
module sim_fp_class_tester;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVALS = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic         dp_sel = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] vec = '0;
  logic         valid_o;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_class_tester u0 (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid_i), .dp_sel_i (dp_sel),
    .insn_i (insn), .vec_i (vec), .valid_o (valid_o), .result_o (result)
  );

  function automatic logic [31:0] sp_val(input int k);
    case (k)
      0: return 32'h7FC0_0000;  1: return 32'hFF80_0001;
      2: return 32'h7F80_0000;  3: return 32'hFF80_0000;
      4: return 32'h0000_0000;  5: return 32'h8000_0000;
      6: return 32'h0000_0001;  7: return 32'h807F_FFFF;
      8: return 32'h3F80_0000;  9: return 32'hC000_0000;
      10: return 32'h7F7F_FFFF; default: return 32'h0080_0000;
    endcase
  endfunction

  function automatic logic [63:0] dp_val(input int k);
    case (k)
      0: return 64'h7FF8_0000_0000_0000;  1: return 64'hFFF0_0000_0000_0001;
      2: return 64'h7FF0_0000_0000_0000;  3: return 64'hFFF0_0000_0000_0000;
      4: return 64'h0000_0000_0000_0000;  5: return 64'h8000_0000_0000_0000;
      6: return 64'h0000_0000_0000_0001;  7: return 64'h800F_FFFF_FFFF_FFFF;
      8: return 64'h3FF0_0000_0000_0000;  9: return 64'hC000_0000_0000_0000;
      10: return 64'h7FEF_FFFF_FFFF_FFFF; default: return 64'h0010_0000_0000_0000;
    endcase
  endfunction

  // arithmetic reference model; returns hit and requirement tag
  function automatic bit ref_hit(input logic [63:0] v, input bit dp,
                                 input logic [6:0] m, output string tag);
    int ew = dp ? 11 : 8;
    int fw = dp ? 52 : 23;
    longint unsigned e = (v >> fw) & ((64'd1 << ew) - 1);
    longint unsigned f = v & ((64'd1 << fw) - 1);
    bit s = v[ew + fw];
    longint unsigned emax = (64'd1 << ew) - 1;
    if (e == emax && f != 0) begin tag = "R5"; return m[6]; end
    if (e == emax)           begin tag = "R6"; return s ? m[4] : m[5]; end
    if (e == 0 && f == 0)    begin tag = "R7"; return s ? m[2] : m[3]; end
    if (e == 0)              begin tag = "R8"; return s ? m[0] : m[1]; end
    tag = "R9";
    return 1'b0;
  endfunction

  function automatic logic [31:0] make_insn(input logic [6:0] m, input logic [31:0] noise);
    logic [31:0] w = noise & ~(32'h001F_0000 | 32'h44);
    w[20:16] = m[4:0];
    w[2]     = m[5];
    w[6]     = m[6];
    return w;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // drive on falling edge, result due after next rising edge, read on next falling edge
  task automatic apply(input bit dp, input logic [6:0] m, input logic [127:0] v);
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    dp_sel  = dp;
    insn    = make_insn(m, lcg);
    vec     = v;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic check_lanes(input bit dp, input logic [6:0] m, input logic [127:0] v);
    string tag;
    bit h;
    checks++;
    if (valid_o !== 1'b1) begin
      errors++;
      $display("FAIL R11 valid_o actual=%b expected=1", valid_o);
    end
    if (dp) begin
      for (int k = 0; k < 2; k++) begin
        h = ref_hit(v[64*k +: 64], 1'b1, m, tag);
        check({"R2 ", tag}, {64'd0, result[64*k +: 64]}, {64'd0, {64{h}}});
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        h = ref_hit({32'd0, v[32*k +: 32]}, 1'b0, m, tag);
        check({"R1 ", tag}, {96'd0, result[32*k +: 32]}, {96'd0, {32{h}}});
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] v;
    logic [127:0] held;
    repeat (2) @(negedge clk);
    // R12: reset state
    check("R12 reset result", result, '0);
    check("R12 reset valid", {127'd0, valid_o}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle valid", {127'd0, valid_o}, 128'd0);

    // sweep all masks x lane rotations in both precisions (R3, R4, R10)
    for (int m = 0; m < 128; m++) begin
      for (int r = 0; r < NVALS; r++) begin
        for (int k = 0; k < 4; k++) v[32*k +: 32] = sp_val((r + k) % NVALS);
        apply(1'b0, m[6:0], v);
        check_lanes(1'b0, m[6:0], v);
        for (int k = 0; k < 2; k++) v[64*k +: 64] = dp_val((r + 3*k) % NVALS);
        apply(1'b1, m[6:0], v);
        check_lanes(1'b1, m[6:0], v);
      end
    end

    // R4: only insn bit 2 set selects +inf
    dp_sel = 1'b0; insn = 32'h0000_0004; vec = {4{32'h7F80_0000}}; valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    check("R4 bit2 -> +inf", result, {128{1'b1}});
    // R4: all non-mask bits set, mask zero
    insn = ~(32'h001F_0044); vec = {4{32'h7FC0_0000}}; valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    check("R4 non-mask bits ignored", result, '0);
    // R10: NaN only in lane 2, NaN selected
    insn = 32'h0000_0040; vec = {32'h3F80_0000, 32'hFFC0_0000, 32'h0000_0000, 32'h0000_0001};
    valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    check("R10 lane isolation", result, {32'h0, 32'hFFFF_FFFF, 64'h0});
    // R3: full-width fill in double mode, lane 1 hits
    dp_sel = 1'b1; insn = 32'h0000_0040;
    vec = {64'hFFF8_0000_0000_0000, 64'h3FF0_0000_0000_0000}; valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    check("R3 double fill", result, {{64{1'b1}}, 64'h0});
    held = result;
    // R12: hold while valid_i low
    vec = '0; insn = 32'h001F_0044;
    @(negedge clk);
    check("R12 hold", result, held);
    check("R11 valid low", {127'd0, valid_o}, 128'd0);
    // R12: reset mid-run clears
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset clears", result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule